// File: doc/BRIEF.md
# Region Access-Map Tracker and Prefetch Filter

This block keeps a short history of second-level cache traffic in units of 4 KiB regions. Every tracked region holds two 64-bit maps with one bit per 64-byte line. One map records demand accesses and the other records prefetches already sent. Demand accesses build up the access map. At moments of activity or quiet, the block reads the map around the line just touched and emits a pair of short patterns for a downstream pattern table. One pattern looks toward higher lines and the other toward lower lines. Because the patterns come from a map and not from the order of arrival, reordered requests give the same result.

Prefetch candidates go through the filter in the same cycle. A candidate whose line is already marked as prefetched in a tracked region is dropped. A candidate that passes is marked so that it cannot be issued again. The mark stays until the region's slot is taken by another region. Slots are replaced least-recently-used, and a new tenant starts with both maps empty.

Top module: `region_map_tracker`

## Requirements
- R1: After reset no pattern is emitted and no prefetch candidate is dropped, because no region is tracked.
- R2: A demand access that brings its region's access count to CNT_THR (default 4) raises `pat_valid` for one cycle, one clock edge after the access. The count then restarts from zero. The accesses before it emit nothing.
- R3: `pat_fwd` bit k is the access-map bit of line `pat_line`+1+k. `pat_line` is the line of the triggering access, which is address bits [11:6].
- R4: `pat_bwd` bit k is the access-map bit of line `pat_line`-1-k.
- R5: Window positions beyond line 63 or below line 0 read as zero.
- R6: A region with a nonzero count that sees no access emits a pattern around its last accessed line exactly 2^IDLE_W clock edges after that access (default 256). Its count and timer then restart.
- R7: `pf_drop` is combinational. It is 1 exactly when `pf_valid` is high, the candidate's region is tracked and its line is marked prefetched. A candidate that is not dropped in a tracked region is marked from the next cycle on.
- R8: Candidates in untracked regions always pass and leave no mark.
- R9: Demand accesses never set prefetch marks.
- R10: The table holds ENTRIES regions (default 16). A new region replaces the least recently accessed one.
- R11: A region that is reallocated after eviction starts with empty access and prefetch maps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Demand access present |
| acc_addr | input | ADDR_W | Demand access byte address |
| pf_valid | input | 1 | Prefetch candidate present |
| pf_addr | input | ADDR_W | Prefetch candidate byte address |
| pf_drop | output | 1 | Candidate is a duplicate and must not issue |
| pat_valid | output | 1 | Pattern pair valid |
| pat_line | output | 6 | Line the patterns are centred on |
| pat_fwd | output | WIN | Upward pattern, bit k = line+1+k |
| pat_bwd | output | WIN | Downward pattern, bit k = line-1-k |

## Verification
A count-triggered pattern is due one edge after the access that completes the count. The driver pushes the expected pair before that access. The monitor compares on the following falling edge. The filter verdict is read 1 ns after the candidate is applied, inside the same cycle, and a mark is checked only on a later query. The quiet-timeout pattern is timed by counting falling edges from the last access until `pat_valid` appears, and the count must equal 256.

// File: rtl/region_map_tracker.sv
module region_map_tracker #(
  parameter int ADDR_W  = 40,
  parameter int ENTRIES = 16,
  parameter int WIN     = 8,
  parameter int CNT_THR = 4,
  parameter int IDLE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              pf_valid,
  input  logic [ADDR_W-1:0] pf_addr,
  output logic              pf_drop,
  output logic              pat_valid,
  output logic [5:0]        pat_line,
  output logic [WIN-1:0]    pat_fwd,
  output logic [WIN-1:0]    pat_bwd
);
  localparam int TAG_W = ADDR_W - 12;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(CNT_THR + 1);

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag  [ENTRIES];
  logic [63:0]        amap [ENTRIES];
  logic [63:0]        pmap [ENTRIES];
  logic [CNT_W-1:0]   cnt  [ENTRIES];
  logic [IDLE_W-1:0]  idle [ENTRIES];
  logic [5:0]         last [ENTRIES];
  logic [IDX_W-1:0]   age  [ENTRIES];

  logic [TAG_W-1:0] acc_tag, pf_tag;
  logic [5:0]       acc_line, pf_line;
  assign acc_tag  = acc_addr[ADDR_W-1:12];
  assign acc_line = acc_addr[11:6];
  assign pf_tag   = pf_addr[ADDR_W-1:12];
  assign pf_line  = pf_addr[11:6];

  logic [ENTRIES-1:0] acc_hv, pf_hv, touch, tmo;
  logic [IDX_W-1:0]   acc_idx, pf_idx, victim, sel, tsel;
  logic               acc_hit, pf_hit, t_any;

  always_comb begin
    acc_hv = '0; pf_hv = '0; touch = '0; tmo = '0;
    acc_idx = '0; pf_idx = '0; victim = '0; tsel = '0; t_any = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      acc_hv[i] = vld[i] && (tag[i] == acc_tag);
      pf_hv[i]  = vld[i] && (tag[i] == pf_tag);
      if (acc_hv[i]) acc_idx = IDX_W'(i);
      if (pf_hv[i])  pf_idx  = IDX_W'(i);
      if (age[i] == IDX_W'(ENTRIES - 1)) victim = IDX_W'(i);
    end
    acc_hit = |acc_hv;
    pf_hit  = |pf_hv;
    sel     = acc_hit ? acc_idx : victim;
    for (int i = 0; i < ENTRIES; i++) begin
      touch[i] = acc_valid && (sel == IDX_W'(i));
      tmo[i]   = vld[i] && (cnt[i] != '0) && (&idle[i]) && !touch[i];
    end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (tmo[i]) begin
        tsel  = IDX_W'(i);
        t_any = 1'b1;
      end
  end

  logic [CNT_W-1:0] cnt_nxt;
  logic             acc_fire, t_fire, pf_mark;
  logic [63:0]      src_map;
  logic [5:0]       src_line;

  assign cnt_nxt  = acc_hit ? cnt[sel] + 1'b1 : CNT_W'(1);
  assign acc_fire = acc_valid && (cnt_nxt == CNT_W'(CNT_THR));
  assign t_fire   = t_any && !acc_fire;
  assign src_map  = acc_fire ? (acc_hit ? amap[sel] : 64'd0) : amap[tsel];
  assign src_line = acc_fire ? acc_line : last[tsel];
  assign pf_drop  = pf_valid && pf_hit && pmap[pf_idx][pf_line];
  assign pf_mark  = pf_valid && pf_hit && !pf_drop;

  function automatic logic [WIN-1:0] win_up(input logic [63:0] m, input logic [5:0] l);
    logic [6:0] p;
    for (int k = 0; k < WIN; k++) begin
      p = {1'b0, l} + 7'(k + 1);
      win_up[k] = !p[6] && m[p[5:0]];
    end
  endfunction

  function automatic logic [WIN-1:0] win_dn(input logic [63:0] m, input logic [5:0] l);
    logic [6:0] p;
    for (int k = 0; k < WIN; k++) begin
      p = {1'b0, l} - 7'(k + 1);
      win_dn[k] = !p[6] && m[p[5:0]];
    end
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      pat_valid <= 1'b0;
      pat_line  <= '0;
      pat_fwd   <= '0;
      pat_bwd   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i]  <= '0;
        amap[i] <= '0;
        pmap[i] <= '0;
        cnt[i]  <= '0;
        idle[i] <= '0;
        last[i] <= '0;
        age[i]  <= IDX_W'(i);
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (touch[i]) begin
          vld[i]  <= 1'b1;
          tag[i]  <= acc_tag;
          cnt[i]  <= acc_fire ? '0 : cnt_nxt;
          idle[i] <= '0;
          last[i] <= acc_line;
          if (acc_hit) begin
            amap[i][acc_line] <= 1'b1;
          end else begin
            amap[i] <= 64'd1 << acc_line;
            pmap[i] <= '0;
          end
        end else if (t_fire && (tsel == IDX_W'(i))) begin
          cnt[i]  <= '0;
          idle[i] <= '0;
        end else if ((cnt[i] != '0) && !(&idle[i])) begin
          idle[i] <= idle[i] + 1'b1;
        end
        if (pf_mark && (pf_idx == IDX_W'(i)) && !(touch[i] && !acc_hit))
          pmap[i][pf_line] <= 1'b1;
        if (acc_valid) begin
          if (touch[i])            age[i] <= '0;
          else if (age[i] < age[sel]) age[i] <= age[i] + 1'b1;
        end
      end
      pat_valid <= acc_fire || t_fire;
      if (acc_fire || t_fire) begin
        pat_line <= src_line;
        pat_fwd  <= win_up(src_map, src_line);
        pat_bwd  <= win_dn(src_map, src_line);
      end
    end
  end
endmodule

// File: rtl/region_map_tracker_chk.sv
module region_map_tracker_chk #(
  parameter int ADDR_W = 40,
  parameter int WIN    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              pf_valid,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              pf_drop,
  input logic              pf_hit,
  input logic              pat_valid,
  input logic [5:0]        pat_line,
  input logic [WIN-1:0]    pat_fwd,
  input logic [WIN-1:0]    pat_bwd
);
  logic seen_acc, seen_mark;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_acc  <= 1'b0;
      seen_mark <= 1'b0;
    end else begin
      if (acc_valid) seen_acc <= 1'b1;
      if (pf_valid && pf_hit && !pf_drop) seen_mark <= 1'b1;
    end
  end

  AST_PAT_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    pat_valid |-> seen_acc); // R2
  AST_DROP_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    pf_drop |-> seen_mark); // R7
  AST_REPEAT_IS_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pf_valid && pf_hit && !pf_drop && !acc_valid) && pf_valid && (pf_addr == $past(pf_addr))) |-> pf_drop); // R7
  AST_FWD_TOP_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_valid && (pat_line == 6'd63)) |-> (pat_fwd == '0)); // R5
  AST_BWD_LOW_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_valid && (pat_line == 6'd0)) |-> (pat_bwd == '0)); // R5
endmodule

bind region_map_tracker region_map_tracker_chk #(.ADDR_W(ADDR_W), .WIN(WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .pf_valid(pf_valid),
  .pf_addr(pf_addr), .pf_drop(pf_drop), .pf_hit(pf_hit), .pat_valid(pat_valid),
  .pat_line(pat_line), .pat_fwd(pat_fwd), .pat_bwd(pat_bwd)
);

// File: tb/region_map_tracker_tb.sv
`timescale 1ns/1ps
module region_map_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, pf_valid = 1'b0;
  logic [39:0] acc_addr = '0, pf_addr = '0;
  logic        pf_drop, pat_valid;
  logic [5:0]  pat_line;
  logic [7:0]  pat_fwd, pat_bwd;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  region_map_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_drop(pf_drop),
    .pat_valid(pat_valid), .pat_line(pat_line), .pat_fwd(pat_fwd), .pat_bwd(pat_bwd)
  );

  logic [21:0] expq [$];
  string       reqq [$];

  function automatic logic [39:0] mk(int r, int l);
    return {28'(r), 6'(l), 6'b0};
  endfunction

  function automatic void chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endfunction

  task automatic expect_pat(string req, int l, logic [7:0] f, logic [7:0] b);
    expq.push_back({6'(l), f, b});
    reqq.push_back(req);
  endtask

  always @(negedge clk) begin
    if (rst_n && pat_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R2 unexpected pattern", {10'd0, pat_line, pat_fwd, pat_bwd}, 32'd0);
      end else begin
        logic [21:0] e;
        string r;
        e = expq.pop_front();
        r = reqq.pop_front();
        chk({pat_line, pat_fwd, pat_bwd} == e, r, {10'd0, pat_line, pat_fwd, pat_bwd}, {10'd0, e});
      end
    end
  end

  task automatic access(int r, int l);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_addr  = mk(r, l);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic query(int r, int l, bit exp_drop, string req);
    @(negedge clk);
    pf_valid = 1'b1;
    pf_addr  = mk(r, l);
    #1;
    chk(pf_drop == exp_drop, req, {31'd0, pf_drop}, {31'd0, exp_drop});
    @(negedge clk);
    pf_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pat_valid == 1'b0, "R1 no pattern after reset", {31'd0, pat_valid}, 32'd0);
    query(1, 0, 1'b0, "R1 nothing tracked");

    // R2, R3, R4: region 1 lines 10,12,9 then 11
    access(1, 10); access(1, 12); access(1, 9);
    chk(pat_valid == 1'b0, "R2 silent before threshold", {31'd0, pat_valid}, 32'd0);
    expect_pat("R3 R4 window around line 11", 11, 8'h01, 8'h03);
    access(1, 11);

    // R5: low edge of region
    access(2, 63); access(2, 62); access(2, 1);
    expect_pat("R5 clipped at line 0", 0, 8'h01, 8'h00);
    access(2, 0);
    // R4 wider backward pattern, R5 at top edge
    access(3, 57); access(3, 58); access(3, 60);
    expect_pat("R4 R5 window around line 63", 63, 8'h00, 8'h34);
    access(3, 63);

    // R6: quiet timeout
    access(4, 5);
    access(4, 7);
    expect_pat("R6 timeout pattern", 7, 8'h00, 8'h02);
    n = 0;
    while (!pat_valid && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(n == 256, "R6 timeout delay", 32'(n), 32'd256);

    // R7, R8, R9: filter
    query(1, 20, 1'b0, "R7 first candidate passes");
    query(1, 20, 1'b1, "R7 repeat candidate dropped");
    query(1, 21, 1'b0, "R7 neighbour line passes");
    query(1, 12, 1'b0, "R9 accessed line not marked");
    query(99, 20, 1'b0, "R8 untracked passes");
    query(99, 20, 1'b0, "R8 untracked leaves no mark");

    // R10: region 1 becomes most recent, then 15 new regions
    for (int k = 0; k < 3; k++) access(1, 20);
    expect_pat("R2 R4 window edge at k=7", 20, 8'h00, 8'h80);
    access(1, 20);
    for (int r = 100; r < 115; r++) begin
      for (int k = 0; k < 3; k++) access(r, 0);
      expect_pat("R2 fill region", 0, 8'h00, 8'h00);
      access(r, 0);
    end
    query(1, 20, 1'b1, "R10 recent region kept");
    for (int k = 0; k < 3; k++) access(115, 0);
    expect_pat("R2 fill region", 0, 8'h00, 8'h00);
    access(115, 0);
    query(1, 20, 1'b0, "R10 LRU region evicted");

    // R11: reallocation starts clean
    for (int k = 0; k < 3; k++) access(1, 3);
    expect_pat("R11 access map cleared", 3, 8'h00, 8'h00);
    access(1, 3);
    query(1, 20, 1'b0, "R11 prefetch map cleared");

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R2 all expected patterns seen", 32'(expq.size()), 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule